// File: doc/BRIEF.md
# Modulo-60 Two-Digit Decimal Divider

This block counts qualifying clock cycles in decimal using two cascaded digit stages. A units stage counts 0 through 9. A tens stage counts 0 through 5 and steps only when the units stage sits at its terminal value. Together they form a modulus of 10 × 6 = 60. A one-cycle pulse marks each completed group of 60 counted cycles. A typical use is reducing a 60 Hz line-derived tick to a 1 Hz tick.

Both stages run on one clock. The input `cnt_en` qualifies the cycles that count. The units stage finds its terminal value by looking only at the set bits of 1001 (bits 3 and 0). The tens stage is cleared when its incremented value would reach 0110, which it finds by looking only at bits 2 and 1. Both clears are applied synchronously, so the out-of-range value never appears on the outputs.

Top module: `mod60_divider`

## Requirements
- R1: With `rst` high at a rising edge, both digits read 0 after that edge; `div_pulse` is low while `rst` is high.
- R2: On each edge with `cnt_en` high and `rst` low, the units digit steps by one (0→1→…→9).
- R3: The units digit goes from 9 to 0 on an enabled edge. Its terminal value is found by bits 3 and 0 of the digit alone.
- R4: The tens digit steps by one only on an enabled edge where the units digit is 9. On every other edge it holds.
- R5: The tens digit goes from 5 to 0 (clear on reaching 6). Both digits always stay in range: units 0..9 and tens 0..5.
- R6: `div_pulse` is high exactly in a cycle where `cnt_en` is high and the count is 59 (tens 5, units 9). It is therefore high once per 60 enabled cycles, and the count is 00 after that edge.
- R7: With `cnt_en` low, both digits hold their value and `div_pulse` is low.
- R8: `rst` takes priority over `cnt_en` when both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both stages |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count qualifier; high means this cycle counts |
| units_digit | output | 4 | Units BCD digit, 0..9 |
| tens_digit | output | 4 | Tens BCD digit, 0..5 |
| div_pulse | output | 1 | One-cycle pulse for each 60 counted cycles |

## Verification
The bench builds the block with its default parameters: a 4-bit digit, a units modulus of 10 and a tens modulus of 6. With these values a full 60-state cycle takes only 60 enabled cycles, so the bench passes through every terminal and clear point many times. Random gaps in the enable and random mid-count resets place the 9→0 carry and the 59→00 rollover next to held cycles and reset cycles. Directed runs cover the first full cycle from reset, long holds, and a reset asserted together with the enable.

// File: rtl/mod60_pkg.sv
package mod60_pkg;

    localparam int DIGIT_W  = 4;
    localparam int UNITS_M  = 10;
    localparam int TENS_M   = 6;

    // How a stage decides to return to zero
    typedef enum logic {
        WRAP_AT_TERMINAL = 1'b0,  // clear when current value has all bits of MOD-1
        CLEAR_AT_MODULUS = 1'b1   // clear when incremented value has all bits of MOD
    } recycle_e;

    typedef struct packed {
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] units;
    } count_t;

    // Partial-decode match: every set bit of pattern is set in value.
    // The first value reached counting up from 0 that matches is pattern itself.
    function automatic logic pattern_hit(input logic [DIGIT_W-1:0] value,
                                         input logic [DIGIT_W-1:0] pattern);
        return (value & pattern) == pattern;
    endfunction

endpackage

// File: rtl/digit_stage.sv
module digit_stage
    import mod60_pkg::*;
#(
    parameter int       MOD     = 10,
    parameter int       W       = DIGIT_W,
    parameter recycle_e RECYCLE = WRAP_AT_TERMINAL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    output logic [W-1:0] q,
    output logic         at_term
);
    localparam logic [W-1:0] TERM_PAT = W'(MOD - 1);
    localparam logic [W-1:0] MOD_PAT  = W'(MOD);

    logic [W-1:0] q_r;
    logic [W-1:0] q_inc;
    logic         recycle;

    assign q_inc   = q_r + W'(1);
    assign at_term = pattern_hit(q_r, TERM_PAT);

    generate
        if (RECYCLE == CLEAR_AT_MODULUS) begin : g_clear_mod
            assign recycle = pattern_hit(q_inc, MOD_PAT);
        end else begin : g_wrap_term
            assign recycle = at_term;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else if (step_en)
            q_r <= recycle ? '0 : q_inc;
    end

    assign q = q_r;

    // R1: reset clears the digit
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> q_r == '0);
    // R7: no step request, digit holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(q_r));
    // R2: ordinary step increments by one
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (step_en && q_r != TERM_PAT) |=> q_r == $past(q_r) + W'(1));
    // R3 / R5: terminal value steps to zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (step_en && q_r == TERM_PAT) |=> q_r == '0);
    // R5: stays in range
    a_r5_in_range: assert property (@(posedge clk) disable iff (rst)
        q_r < MOD_PAT);

endmodule

// File: rtl/mod60_divider.sv
module mod60_divider
    import mod60_pkg::*;
#(
    parameter int W      = DIGIT_W,
    parameter int LOW_M  = UNITS_M,
    parameter int HIGH_M = TENS_M
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    output logic [W-1:0] units_digit,
    output logic [W-1:0] tens_digit,
    output logic         div_pulse
);
    localparam int NSTAGE = 2;

    logic [NSTAGE-1:0] stage_en;
    logic [NSTAGE-1:0] stage_term;
    count_t            cnt;

    // Cascade: each stage enabled only while all lower stages are terminal
    assign stage_en[0] = cnt_en & ~rst;
    assign stage_en[1] = stage_en[0] & stage_term[0];

    digit_stage #(.MOD(LOW_M), .W(W), .RECYCLE(WRAP_AT_TERMINAL)) u_units (
        .clk     (clk),
        .rst     (rst),
        .step_en (stage_en[0]),
        .q       (cnt.units),
        .at_term (stage_term[0])
    );

    digit_stage #(.MOD(HIGH_M), .W(W), .RECYCLE(CLEAR_AT_MODULUS)) u_tens (
        .clk     (clk),
        .rst     (rst),
        .step_en (stage_en[1]),
        .q       (cnt.tens),
        .at_term (stage_term[1])
    );

    assign units_digit = cnt.units;
    assign tens_digit  = cnt.tens;
    assign div_pulse   = stage_en[1] & stage_term[1];

    // R4: tens holds unless units carried
    a_r4_tens_only_on_carry: assert property (@(posedge clk) disable iff (rst)
        !(cnt_en && cnt.units == W'(LOW_M - 1)) |=> $stable(cnt.tens));
    // R6: pulse returns the count to 00
    a_r6_pulse_rollover: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> (cnt.units == '0 && cnt.tens == '0));
    // R6: pulse only at the top count
    a_r6_pulse_at_top: assert property (@(posedge clk)
        div_pulse |-> (cnt.units == W'(LOW_M - 1) && cnt.tens == W'(HIGH_M - 1)));
    // R7 / R8: no pulse without enable or during reset
    a_r8_no_pulse_idle: assert property (@(posedge clk)
        (rst || !cnt_en) |-> !div_pulse);

endmodule

// File: tb/mod60_divider_test.sv
module mod60_divider_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en;
    logic [3:0] units_digit;
    logic [3:0] tens_digit;
    logic       div_pulse;

    int checks = 0;
    int fails  = 0;
    int model  = 0;     // expected count 0..59
    bit done   = 0;

    always #5 clk = ~clk;

    mod60_divider uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .units_digit(units_digit), .tens_digit(tens_digit), .div_pulse(div_pulse)
    );

    function automatic int exp_units(input int m); return m % 10; endfunction
    function automatic int exp_tens(input int m);  return m / 10; endfunction
    function automatic bit exp_pulse(input int m, input bit e, input bit r);
        return e && !r && (m == 59);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at falling edge, check pulse, then check digits after edge
    task automatic step(input bit e, input bit r, input string req);
        bit pe;
        @(negedge clk);
        cnt_en = e;
        rst    = r;
        #1;
        pe = exp_pulse(model, e, r);
        check({req, " pulse"}, int'(div_pulse), int'(pe));
        @(posedge clk);
        #1;
        if (r) model = 0;
        else if (e) model = (model + 1) % 60;
        check({req, " units"}, int'(units_digit), exp_units(model));
        check({req, " tens"},  int'(tens_digit),  exp_tens(model));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int pulses;
        void'($urandom(32'h5EED_0060));
        rst = 1'b1;
        cnt_en = 1'b0;
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, "R1");

        // R7: hold with enable low
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R7");

        // R2/R3/R4/R5/R6: first full cycle from reset, count pulses
        pulses = 0;
        for (int i = 0; i < 600; i++) begin
            step(1'b1, 1'b0, "R6");
            if (model == 0) pulses++;
        end
        check("R6 pulses per 600", pulses, 10);

        // R3: stop at 9, hold, then carry
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0, "R2");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, "R3");
        check("R4 tens after carry", int'(tens_digit), 1);

        // R6/R7: sit at 59 with enable low, no pulse
        while (model != 59) step(1'b1, 1'b0, "R5");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, "R6");
        check("R5 tens after 59", int'(tens_digit), 0);

        // R8: reset together with enable, at the top count
        while (model != 59) step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b1, "R8");

        // Random phase: gaps in enable, rare resets
        for (int i = 0; i < 4000; i++) begin
            bit e, r;
            e = ($urandom % 10) < 7;
            r = ($urandom % 200) == 0;
            step(e, r, "R4");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule